// File: doc/BRIEF.md
# Threshold Receive FIFO with Block Interrupts

This block buffers bytes coming from a channel receiver and tells a host processor when there is work to do. It holds up to 128 bytes. It raises a message-ready interrupt each time a block of threshold size is waiting, and the host selects a threshold of 64 or 96 bytes. In framed mode it also raises an end-of-message interrupt when a frame-end marker arrives. With that interrupt it latches the length of the frame's remaining part, so the host knows how many bytes to read. In transparent mode frame-end markers are ignored and only threshold blocks are reported.

The host drains bytes through a simple read port and then issues an acknowledge. The acknowledge is the only way storage is returned: it releases the whole block that the interrupt announced, including any bytes of that block the host did not read. After a release the block re-evaluates what is waiting and raises the next interrupt if a further block or frame end is already stored. A byte that arrives while all 128 places hold unreleased data is dropped. A dropped byte raises a one-cycle overflow pulse and sets a sticky status bit, which stays set until the host reads status.

At 64 kbps a 64-byte threshold gives the host about 8 ms to respond before the buffer fills.

Top module: `rxf_thr_fifo`

## Requirements
- R1: After reset, all interrupt outputs are 0, the status word is 0 and the frame byte count is 0.
- R2: Stored bytes are returned in arrival order. The read data port always shows the oldest unread byte, and a read strobe advances to the next byte.
- R3: The message-ready interrupt goes high on the clock edge after the one that stores the byte that brings the unreleased byte count up to the threshold. The threshold is 64 when the threshold select is 0 and 96 when it is 1. The interrupt then stays high until an acknowledge.
- R4: In framed mode, when the unreleased part of the oldest pending frame is no longer than the threshold, the end-of-message interrupt is raised and that length is latched on the byte count output. When the length equals the threshold, end-of-message is raised instead of message-ready. The two interrupts are never high together.
- R5: In transparent mode (framed select 0), frame-end markers have no effect and end-of-message is never raised.
- R6: An acknowledge while an interrupt is high releases that block: the threshold count for message-ready, or the latched count for end-of-message. The interrupt drops on the next edge, and unread bytes of that block are skipped. If another block is already waiting, the next interrupt rises one edge later. An acknowledge while no interrupt is high has no effect.
- R7: A byte that arrives while 128 unreleased bytes are held is dropped. The overflow interrupt pulses high for exactly one cycle, and status bit 2 is set.
- R8: A status read strobe clears status bit 2 on the next edge. A drop in the same cycle wins, so the bit stays set.
- R9: Status bit 0 shows the message-ready interrupt and status bit 1 shows the end-of-message interrupt.
- R10: A frame longer than the threshold is reported as one or more message-ready blocks, then an end-of-message for the remainder, with the remainder as the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| framed_i | input | 1 | 1 = framed mode, 0 = transparent mode |
| thr_hi_i | input | 1 | Threshold select: 0 = 64 bytes, 1 = 96 bytes |
| in_valid_i | input | 1 | Incoming byte valid |
| in_data_i | input | 8 | Incoming byte |
| in_eof_i | input | 1 | Incoming byte is the last one of a frame |
| rd_en_i | input | 1 | Host read strobe |
| rd_data_o | output | 8 | Oldest unread byte |
| ack_i | input | 1 | Receive acknowledge command |
| stat_rd_i | input | 1 | Host status read strobe |
| irq_rmr_o | output | 1 | Message-ready interrupt |
| irq_rme_o | output | 1 | End-of-message interrupt |
| irq_ovf_o | output | 1 | Overflow interrupt pulse |
| stat_o | output | 3 | Status: bit 0 message-ready, bit 1 end-of-message, bit 2 sticky overflow |
| count_o | output | 8 | Byte count latched at end-of-message |

## Verification
The bench first uses directed streams that land one byte below and exactly on each threshold, to pin down the one-edge interrupt latency. Frames of 10 bytes, exactly 64 bytes and 100 bytes then separate a short frame, a tie between frame end and threshold, and a frame split into a block plus a remainder. A 130-byte burst separates dropping from storing and shows that an acknowledge re-arms the interrupt when a second block is already held. An acknowledge with no interrupt pending shows that nothing is released. A run of frames with random lengths and random thresholds checks the interrupt kind, the count and every data byte against a length-based prediction.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RMR  = 2'd1,
    ST_RME  = 2'd2
  } irq_st_e;
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxf_eofq.sv
// Small queue of frame-end write pointers, oldest at head.
module rxf_eofq #(
  parameter int PW = 8,
  parameter int NQ = 4,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [PW-1:0] ptr_i,
  input  logic          pop_i,
  output logic [PW-1:0] head_o,
  output logic          vld_o
);
  logic [PW-1:0] ent_q [NQ];
  logic [QW-1:0] wr_q, rd_q;
  logic [QW:0]   cnt_q;
  logic          do_push, do_pop;

  assign vld_o   = cnt_q != '0;
  assign do_push = push_i && (cnt_q != (QW+1)'(NQ));
  assign do_pop  = pop_i && vld_o;
  assign head_o  = ent_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < NQ; i++) ent_q[i] <= '0;
    end else begin
      if (do_push) begin
        ent_q[wr_q] <= ptr_i;
        wr_q        <= wr_q + 1'b1;
      end
      if (do_pop) rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + (QW+1)'(do_push) - (QW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/rxf_irq_ctrl.sv
// Picks the next block to announce and holds it until acknowledge.
module rxf_irq_ctrl
  import rxf_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          framed_i,
  input  logic [PW-1:0] thr_i,
  input  logic [PW-1:0] avail_i,
  input  logic [PW-1:0] flen_i,
  input  logic          fvld_i,
  input  logic          ack_i,
  output irq_st_e       st_o,
  output logic [PW-1:0] blk_len_o,
  output logic [PW-1:0] count_o,
  output logic          pop_o
);
  irq_st_e       st_q;
  logic [PW-1:0] blk_q, cnt_q;
  logic          frm_rdy, blk_rdy;

  // frame end wins on a tie with the threshold
  assign frm_rdy = framed_i && fvld_i && (flen_i <= thr_i);
  assign blk_rdy = avail_i >= thr_i;
  assign pop_o   = (st_q == ST_IDLE) && frm_rdy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      blk_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (frm_rdy) begin
            st_q  <= ST_RME;
            blk_q <= flen_i;
            cnt_q <= flen_i;
          end else if (blk_rdy) begin
            st_q  <= ST_RMR;
            blk_q <= thr_i;
          end
        end
        default: if (ack_i) st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o      = st_q;
  assign blk_len_o = blk_q;
  assign count_o   = cnt_q;
endmodule

// File: rtl/rxf_thr_fifo.sv
module rxf_thr_fifo
  import rxf_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 128,
  parameter int THR_LO = 64,
  parameter int THR_HI = 96,
  parameter int NFRM   = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          framed_i,
  input  logic          thr_hi_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_eof_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          ack_i,
  input  logic          stat_rd_i,
  output logic          irq_rmr_o,
  output logic          irq_rme_o,
  output logic          irq_ovf_o,
  output logic [2:0]    stat_o,
  output logic [PW-1:0] count_o
);
  logic [PW-1:0] wr_ptr, rd_ptr, rel_ptr;
  logic [PW-1:0] avail, thr, flen, eq_head, blk_len, rel_next;
  logic          full, wr_ok, drop, ack_ok, eq_vld, eq_pop;
  logic          ovf_pulse_q, ovf_sticky_q;
  irq_st_e       st;

  assign avail    = wr_ptr - rel_ptr;
  assign full     = avail == PW'(DEPTH);
  assign wr_ok    = in_valid_i && !full;
  assign drop     = in_valid_i && full;
  assign thr      = thr_hi_i ? PW'(THR_HI) : PW'(THR_LO);
  assign flen     = eq_head - rel_ptr;
  assign ack_ok   = ack_i && (st != ST_IDLE);
  assign rel_next = rel_ptr + blk_len;

  rxf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_ok),
    .waddr_i (wr_ptr[AW-1:0]),
    .wdata_i (in_data_i),
    .raddr_i (rd_ptr[AW-1:0]),
    .rdata_o (rd_data_o)
  );

  // eof pointer marks the position just past the frame's last byte
  rxf_eofq #(.PW(PW), .NQ(NFRM)) u_eofq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (framed_i && in_valid_i && in_eof_i),
    .ptr_i  (wr_ptr + PW'(wr_ok)),
    .pop_i  (eq_pop),
    .head_o (eq_head),
    .vld_o  (eq_vld)
  );

  rxf_irq_ctrl #(.PW(PW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .framed_i  (framed_i),
    .thr_i     (thr),
    .avail_i   (avail),
    .flen_i    (flen),
    .fvld_i    (eq_vld),
    .ack_i     (ack_i),
    .st_o      (st),
    .blk_len_o (blk_len),
    .count_o   (count_o),
    .pop_o     (eq_pop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      rel_ptr <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (ack_ok) begin
        rel_ptr <= rel_next;
        rd_ptr  <= rel_next;
      end else if (rd_en_i && (rd_ptr != wr_ptr)) begin
        rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_pulse_q  <= 1'b0;
      ovf_sticky_q <= 1'b0;
    end else begin
      ovf_pulse_q  <= drop;
      ovf_sticky_q <= drop || (ovf_sticky_q && !stat_rd_i);
    end
  end

  assign irq_rmr_o = st == ST_RMR;
  assign irq_rme_o = st == ST_RME;
  assign irq_ovf_o = ovf_pulse_q;
  assign stat_o    = {ovf_sticky_q, irq_rme_o, irq_rmr_o};
endmodule

// File: rtl/rxf_thr_fifo_chk.sv
module rxf_thr_fifo_chk #(
  parameter int PW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          framed_i,
  input logic          in_valid_i,
  input logic          ack_i,
  input logic          stat_rd_i,
  input logic          irq_rmr_o,
  input logic          irq_rme_o,
  input logic          irq_ovf_o,
  input logic [2:0]    stat_o,
  input logic          full,
  input logic [PW-1:0] wr_ptr
);
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && full |=> $stable(wr_ptr)); // R7
  AST_OVF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && full |=> irq_ovf_o && stat_o[2]); // R7
  AST_IRQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_rmr_o && irq_rme_o)); // R4
  AST_NO_RME_TRANSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !framed_i |=> !$rose(irq_rme_o)); // R5
  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && (irq_rmr_o || irq_rme_o) |=> !irq_rmr_o && !irq_rme_o); // R6
  AST_RMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rmr_o && !ack_i |=> irq_rmr_o); // R3
  AST_STAT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !(in_valid_i && full) |=> !stat_o[2]); // R8
endmodule

bind rxf_thr_fifo rxf_thr_fifo_chk #(.PW(PW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .framed_i   (framed_i),
  .in_valid_i (in_valid_i),
  .ack_i      (ack_i),
  .stat_rd_i  (stat_rd_i),
  .irq_rmr_o  (irq_rmr_o),
  .irq_rme_o  (irq_rme_o),
  .irq_ovf_o  (irq_ovf_o),
  .stat_o     (stat_o),
  .full       (full),
  .wr_ptr     (wr_ptr)
);

// File: tb/rxf_thr_fifo_tb.sv
module rxf_thr_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       framed_i = 1'b0, thr_hi_i = 1'b0;
  logic       in_valid_i = 1'b0, in_eof_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       rd_en_i = 1'b0, ack_i = 1'b0, stat_rd_i = 1'b0;
  logic [7:0] rd_data_o, count_o;
  logic       irq_rmr_o, irq_rme_o, irq_ovf_o;
  logic [2:0] stat_o;

  int n_chk = 0, n_fail = 0, held = 0;
  bit done = 0;
  logic [7:0] expq[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rxf_thr_fifo u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .framed_i(framed_i), .thr_hi_i(thr_hi_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_eof_i(in_eof_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .ack_i(ack_i), .stat_rd_i(stat_rd_i),
    .irq_rmr_o(irq_rmr_o), .irq_rme_o(irq_rme_o), .irq_ovf_o(irq_ovf_o),
    .stat_o(stat_o), .count_o(count_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic push(logic [7:0] d, logic eof);
    in_valid_i = 1'b1; in_data_i = d; in_eof_i = eof;
    step();
    in_valid_i = 1'b0; in_eof_i = 1'b0;
    if (held < DEPTH) begin
      expq.push_back(d);
      held++;
    end
  endtask

  task automatic push_n(int n, bit eof_last, bit rnd_eof);
    for (int i = 0; i < n; i++)
      push(8'($urandom), (eof_last && i == n-1) || (rnd_eof && ($urandom % 7 == 0)));
  endtask

  // read n bytes of the announced block, then acknowledge
  task automatic serve(int n, string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = expq.pop_front();
      chk(req, rd_data_o, e);
      rd_en_i = 1'b1;
      step();
      rd_en_i = 1'b0;
    end
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    held -= n;
  endtask

  function automatic int thr_of(bit hi);
    return hi ? 96 : 64;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    #(CLK_PERIOD*2 + 2);
    chk("R1 rmr", irq_rmr_o, 0);
    chk("R1 rme", irq_rme_o, 0);
    chk("R1 ovf", irq_ovf_o, 0);
    chk("R1 stat", stat_o, 0);
    chk("R1 count", count_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();

    // transparent, threshold 64, stray eof markers ignored
    push_n(63, 0, 1);
    chk("R3 below threshold", irq_rmr_o, 0);
    push_n(1, 1, 0);
    chk("R3 latency", irq_rmr_o, 0);
    step();
    chk("R3 rmr at threshold", irq_rmr_o, 1);
    chk("R5 no rme transparent", irq_rme_o, 0);
    chk("R9 stat mirror", stat_o, 3'b001);
    serve(64, "R2 data order");
    chk("R6 ack drops rmr", irq_rmr_o, 0);
    step();
    chk("R6 no rearm when empty", irq_rmr_o, 0);

    // acknowledge with nothing pending releases nothing
    push_n(10, 0, 0);
    ack_i = 1'b1; step(); ack_i = 1'b0;
    push_n(54, 0, 0);
    step();
    chk("R6 idle ack ignored rmr", irq_rmr_o, 1);
    serve(64, "R6 idle ack kept data");

    // overflow burst and re-arm
    push_n(128, 0, 0);
    chk("R7 no ovf while space", irq_ovf_o, 0);
    push(8'hA5, 0);
    chk("R7 ovf pulse", irq_ovf_o, 1);
    chk("R7 sticky", stat_o[2], 1);
    push(8'h5A, 0);
    step();
    chk("R7 pulse one cycle", irq_ovf_o, 0);
    chk("R7 sticky held", stat_o[2], 1);
    serve(64, "R7 first block");
    chk("R6 drop after ack", irq_rmr_o, 0);
    step();
    chk("R6 rearm waiting block", irq_rmr_o, 1);
    serve(64, "R7 dropped bytes absent");
    stat_rd_i = 1'b1; step(); stat_rd_i = 1'b0;
    chk("R8 status read clears", stat_o[2], 0);

    // threshold 96
    thr_hi_i = 1'b1;
    push_n(95, 0, 0);
    step();
    chk("R3 below 96", irq_rmr_o, 0);
    push_n(1, 0, 0);
    step();
    chk("R3 rmr at 96", irq_rmr_o, 1);
    serve(96, "R2 data thr96");

    // framed mode
    framed_i = 1'b1; thr_hi_i = 1'b0;
    push_n(10, 1, 0);
    step();
    chk("R4 rme short frame", irq_rme_o, 1);
    chk("R4 rmr low", irq_rmr_o, 0);
    chk("R4 count", count_o, 10);
    chk("R9 stat rme", stat_o, 3'b010);
    serve(10, "R4 frame data");

    push_n(64, 1, 0);
    step();
    chk("R4 tie rme", irq_rme_o, 1);
    chk("R4 tie rmr low", irq_rmr_o, 0);
    chk("R4 tie count", count_o, 64);
    serve(64, "R4 tie data");

    push_n(100, 1, 0);
    step();
    chk("R10 first part rmr", irq_rmr_o, 1);
    serve(64, "R10 block data");
    step();
    chk("R10 remainder rme", irq_rme_o, 1);
    chk("R10 remainder count", count_o, 36);
    serve(36, "R10 remainder data");

    // random frames with random thresholds
    for (int f = 0; f < 20; f++) begin
      int len, rem, th;
      len = 1 + int'($urandom % 120);
      thr_hi_i = 1'($urandom);
      th = thr_of(thr_hi_i);
      push_n(len, 1, 0);
      rem = len;
      while (rem > 0) begin
        step();
        if (rem <= th) begin
          chk("R4 rnd rme", irq_rme_o, 1);
          chk("R4 rnd count", count_o, rem);
          serve(rem, "R2 rnd data");
          rem = 0;
        end else begin
          chk("R10 rnd rmr", irq_rmr_o, 1);
          serve(th, "R2 rnd data");
          rem -= th;
        end
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule